// File: doc/BRIEF.md
# Floating-point class mask generator

This block sorts an IEEE-754 operand into one of ten categories and reports the result as a one-hot mask. The operand arrives as a raw bit pattern together with a format select that chooses single or double precision. The unit splits the operand into sign, exponent and mantissa, reduces the exponent and mantissa to a few summary flags, and encodes those flags into a 10-bit mask. The mask is then zero-extended to the destination register width.

The result and its valid strobe appear one clock after the request. A pipeline stage that sits next to an FPU register file can use the mask to branch on operand kind, or write it back as an integer.

A parameter removes the double-precision path. In that build the operand narrows to 32 bits and the format select is ignored.

Top module: `fpclass_unit`

## Requirements
- R1: Whenever `out_valid` is high, exactly one of `class_mask[9:0]` is set. A zero mask never occurs.
- R2: The mask bits are assigned as follows. Bit 0 is a signaling NaN and bit 1 is a quiet NaN. Bits 2, 3, 4 and 5 are negative infinity, negative normal, negative subnormal and negative zero. Bits 6, 7, 8 and 9 are positive infinity, positive normal, positive subnormal and positive zero.
- R3: When `fmt_dbl` is 0, the operand is single precision. The sign is bit 31, the exponent is bits 30:23 and the mantissa is bits 22:0. Operand bits 63:32 have no effect on the result.
- R4: When `fmt_dbl` is 1 and the double path is built, the sign is bit 63, the exponent is bits 62:52 and the mantissa is bits 51:0.
- R5: An all-ones exponent with a nonzero mantissa is a NaN. The NaN is quiet when the mantissa MSB is 1 and signaling when it is 0. The sign does not matter for a NaN.
- R6: An all-ones exponent with a zero mantissa is infinity, and the sign picks bit 2 or bit 6.
- R7: A zero exponent is a subnormal when the mantissa is nonzero and a zero when the mantissa is zero. The sign picks the negative or positive bit.
- R8: Every bit of `class_mask` above bit 9 is always 0.
- R9: `out_valid` equals `in_valid` delayed by one clock. The mask for a request is visible in the same cycle that `out_valid` rises.
- R10: While `in_valid` is low, `class_mask` holds its last value whatever the operand does.
- R11: While `rst_n` is low, `out_valid` and `class_mask` are 0.
- R12: With `SUPPORT_DOUBLE` = 0, the operand is 32 bits wide and is always single precision, whatever `fmt_dbl` says.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe. The operand is classified in this cycle. |
| fmt_dbl | input | 1 | 1 selects double precision, 0 selects single precision |
| operand | input | OP_W (64, or 32 when single-only) | Raw IEEE-754 bit pattern |
| out_valid | output | 1 | Registered copy of `in_valid` |
| class_mask | output | XLEN | One-hot class in bits 9:0, zero above |

## Verification
The bench builds two copies of the block. The first uses the defaults `XLEN` = 64 and `SUPPORT_DOUBLE` = 1. This copy covers both field layouts and the zero padding across 54 upper bits. It also covers the case where a single-precision request carries high-half bits that would change a double-precision answer. The second copy uses `XLEN` = 16 and `SUPPORT_DOUBLE` = 0. It shows that the single-only variant ignores the format select and that padding works on a narrow destination. Each of the ten classes is hit in both formats, including the extremes of the largest finite value and the smallest and largest subnormals.

// File: rtl/fpclass_pkg.sv
package fpclass_pkg;

   // class mask width and bit positions (position is the encoding)
   localparam int unsigned CLS_W     = 10;
   localparam int unsigned CLS_SNAN  = 0;
   localparam int unsigned CLS_QNAN  = 1;
   localparam int unsigned CLS_NINF  = 2;
   localparam int unsigned CLS_NNORM = 3;
   localparam int unsigned CLS_NSUB  = 4;
   localparam int unsigned CLS_NZERO = 5;
   localparam int unsigned CLS_PINF  = 6;
   localparam int unsigned CLS_PNORM = 7;
   localparam int unsigned CLS_PSUB  = 8;
   localparam int unsigned CLS_PZERO = 9;

   // field widths of the two formats
   localparam int unsigned SP_EXP_W = 8;
   localparam int unsigned SP_MAN_W = 23;
   localparam int unsigned DP_EXP_W = 11;
   localparam int unsigned DP_MAN_W = 52;
   localparam int unsigned SP_TOT_W = 1 + SP_EXP_W + SP_MAN_W;
   localparam int unsigned DP_TOT_W = 1 + DP_EXP_W + DP_MAN_W;

   typedef logic [CLS_W-1:0] cls_mask_t;

   // format-independent reduction of an operand
   typedef struct packed {
      logic sign;
      logic exp_ones;
      logic exp_zero;
      logic man_nz;
      logic man_msb;
   } fp_summary_t;

endpackage

// File: rtl/fp_field_summary.sv
module fp_field_summary
   import fpclass_pkg::*;
#(
   parameter int unsigned EXP_W = 8,
   parameter int unsigned MAN_W = 23,
   localparam int unsigned TOT_W = 1 + EXP_W + MAN_W
) (
   input  logic [TOT_W-1:0] bits_in,
   output fp_summary_t      summ
);

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;

   assign exp_f = bits_in[TOT_W-2 -: EXP_W];
   assign man_f = bits_in[MAN_W-1:0];

   always_comb begin
      summ.sign     = bits_in[TOT_W-1];
      summ.exp_ones = &exp_f;
      summ.exp_zero = ~|exp_f;
      summ.man_nz   = |man_f;
      summ.man_msb  = man_f[MAN_W-1];
   end

endmodule

// File: rtl/fp_class_encode.sv
module fp_class_encode
   import fpclass_pkg::*;
(
   input  fp_summary_t summ,
   output cls_mask_t   mask
);

   always_comb begin
      mask = '0;
      if (summ.exp_ones) begin
         if (summ.man_nz)
            mask[summ.man_msb ? CLS_QNAN : CLS_SNAN] = 1'b1;
         else
            mask[summ.sign ? CLS_NINF : CLS_PINF] = 1'b1;
      end else if (summ.exp_zero) begin
         if (summ.man_nz)
            mask[summ.sign ? CLS_NSUB : CLS_PSUB] = 1'b1;
         else
            mask[summ.sign ? CLS_NZERO : CLS_PZERO] = 1'b1;
      end else begin
         mask[summ.sign ? CLS_NNORM : CLS_PNORM] = 1'b1;
      end
   end

endmodule

// File: rtl/fpclass_unit.sv
module fpclass_unit
   import fpclass_pkg::*;
#(
   parameter int unsigned XLEN           = 64,
   parameter bit          SUPPORT_DOUBLE = 1'b1,
   localparam int unsigned OP_W = SUPPORT_DOUBLE ? DP_TOT_W : SP_TOT_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic            fmt_dbl,
   input  logic [OP_W-1:0] operand,
   output logic            out_valid,
   output logic [XLEN-1:0] class_mask
);

   // elaboration-time parameter checks
   if (XLEN < CLS_W) begin : g_bad_xlen
      $error("fpclass_unit: XLEN must hold the class mask");
   end

   fp_summary_t sp_summ;
   fp_summary_t sel_summ;
   cls_mask_t   cls_nxt;
   cls_mask_t   mask_q;

   fp_field_summary #(
      .EXP_W (SP_EXP_W),
      .MAN_W (SP_MAN_W)
   ) u_sp_fields (
      .bits_in (operand[SP_TOT_W-1:0]),
      .summ    (sp_summ)
   );

   if (SUPPORT_DOUBLE) begin : g_dp
      fp_summary_t dp_summ;
      fp_field_summary #(
         .EXP_W (DP_EXP_W),
         .MAN_W (DP_MAN_W)
      ) u_dp_fields (
         .bits_in (operand),
         .summ    (dp_summ)
      );
      assign sel_summ = fmt_dbl ? dp_summ : sp_summ;
   end else begin : g_sp_only
      assign sel_summ = sp_summ;
   end

   fp_class_encode u_encode (
      .summ (sel_summ),
      .mask (cls_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         mask_q    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid)
            mask_q <= cls_nxt;
      end
   end

   if (XLEN > CLS_W) begin : g_pad
      assign class_mask = {{(XLEN-CLS_W){1'b0}}, mask_q};
   end else begin : g_exact
      assign class_mask = mask_q;
   end

endmodule

// File: rtl/fpclass_chk.sv
module fpclass_chk #(
   parameter int unsigned XLEN           = 64,
   parameter bit          SUPPORT_DOUBLE = 1'b1,
   parameter int unsigned OP_W           = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            fmt_dbl,
   input logic [OP_W-1:0] operand,
   input logic            out_valid,
   input logic [XLEN-1:0] class_mask
);

   logic sp_req;
   assign sp_req = in_valid && (!SUPPORT_DOUBLE || !fmt_dbl);

   // R1
   one_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones(class_mask[9:0]) == 1));

   // R9
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R9
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R10
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(class_mask));

   // R5
   sp_snan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_req && (&operand[30:23]) && !operand[22] && (|operand[21:0]))
      |=> class_mask[0]);

   // R6
   sp_ninf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_req && operand[31] && (&operand[30:23]) && !(|operand[22:0]))
      |=> class_mask[2]);

   if (XLEN > 10) begin : g_upper
      // R8
      upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         class_mask[XLEN-1:10] == '0);
   end

   if (SUPPORT_DOUBLE) begin : g_dp
      // R5
      dp_qnan_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && fmt_dbl && (&operand[62:52]) && operand[51])
         |=> class_mask[1]);
   end

endmodule

bind fpclass_unit fpclass_chk #(
   .XLEN           (XLEN),
   .SUPPORT_DOUBLE (SUPPORT_DOUBLE),
   .OP_W           (OP_W)
) u_fpclass_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .fmt_dbl    (fmt_dbl),
   .operand    (operand),
   .out_valid  (out_valid),
   .class_mask (class_mask)
);

// File: tb/test_fpclass_unit.sv
module test_fpclass_unit;

   localparam int CLK_PERIOD = 10;
   localparam int NXLEN      = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        fmt_dbl = 1'b0;
   logic [63:0] operand = '0;
   logic        out_valid;
   logic [63:0] class_mask;

   logic             in_valid_n = 1'b0;
   logic             fmt_dbl_n = 1'b0;
   logic [31:0]      operand_n = '0;
   logic             out_valid_n;
   logic [NXLEN-1:0] class_mask_n;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpclass_unit #(.XLEN(64), .SUPPORT_DOUBLE(1'b1)) i_fpclass_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_dbl(fmt_dbl),
      .operand(operand), .out_valid(out_valid), .class_mask(class_mask));

   fpclass_unit #(.XLEN(NXLEN), .SUPPORT_DOUBLE(1'b0)) i_fpclass_unit_narrow (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid_n), .fmt_dbl(fmt_dbl_n),
      .operand(operand_n), .out_valid(out_valid_n), .class_mask(class_mask_n));

   task automatic check(input bit ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one request on the wide copy, result checked a cycle later
   task automatic run_one(input logic dbl, input logic [63:0] op,
                          input logic [9:0] exp, input string tag);
      @(negedge clk);
      in_valid = 1'b1;
      fmt_dbl  = dbl;
      operand  = op;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid === 1'b1 && class_mask === {54'b0, exp}, tag,
            {out_valid, class_mask[62:0]}, {1'b1, 53'b0, exp});
   endtask

   task automatic t_reset;
      @(negedge clk);
      check(out_valid === 1'b0 && class_mask === '0, "R11 reset wide",
            {63'b0, out_valid} | class_mask, 64'h0);
      check(out_valid_n === 1'b0 && class_mask_n === '0, "R11 reset narrow",
            {47'b0, out_valid_n, class_mask_n}, 64'h0);
   endtask

   task automatic t_single_classes;
      run_one(1'b0, 64'h0000_0000, 10'h200, "R7 R2 single +zero");
      run_one(1'b0, 64'h8000_0000, 10'h020, "R7 R2 single -zero");
      run_one(1'b0, 64'h7F80_0000, 10'h040, "R6 single +inf");
      run_one(1'b0, 64'hFF80_0000, 10'h004, "R6 single -inf");
      run_one(1'b0, 64'h7FC0_0000, 10'h002, "R5 single qNaN");
      run_one(1'b0, 64'h7F80_0001, 10'h001, "R5 single sNaN");
      run_one(1'b0, 64'hFFC0_0001, 10'h002, "R5 single negative qNaN");
      run_one(1'b0, 64'h3F80_0000, 10'h080, "R2 R3 single +norm");
      run_one(1'b0, 64'hC000_0000, 10'h008, "R2 R3 single -norm");
      run_one(1'b0, 64'h0000_0001, 10'h100, "R7 single +sub smallest");
      run_one(1'b0, 64'h807F_FFFF, 10'h010, "R7 single -sub largest");
   endtask

   task automatic t_single_ignores_upper;
      run_one(1'b0, 64'hFFF0_0000_3F80_0000, 10'h080, "R3 single ignores high half");
      run_one(1'b0, 64'h7FF8_0000_0000_0000, 10'h200, "R3 single ignores high NaN");
   endtask

   task automatic t_double_classes;
      run_one(1'b1, 64'h0000_0000_0000_0000, 10'h200, "R4 double +zero");
      run_one(1'b1, 64'h8000_0000_0000_0000, 10'h020, "R4 double -zero");
      run_one(1'b1, 64'h7FF0_0000_0000_0000, 10'h040, "R6 double +inf");
      run_one(1'b1, 64'hFFF0_0000_0000_0000, 10'h004, "R6 double -inf");
      run_one(1'b1, 64'h7FF8_0000_0000_0000, 10'h002, "R5 double qNaN");
      run_one(1'b1, 64'h7FF4_0000_0000_0000, 10'h001, "R5 double sNaN");
      run_one(1'b1, 64'h3FF0_0000_0000_0000, 10'h080, "R4 double +norm");
      run_one(1'b1, 64'hC000_0000_0000_0000, 10'h008, "R4 double -norm");
      run_one(1'b1, 64'h7FEF_FFFF_FFFF_FFFF, 10'h080, "R4 double max finite");
      run_one(1'b1, 64'h000F_FFFF_FFFF_FFFF, 10'h100, "R7 double +sub");
      run_one(1'b1, 64'h8000_0000_0000_0001, 10'h010, "R7 double -sub");
      run_one(1'b1, 64'h0000_0000_7F80_0000, 10'h100, "R4 double ignores single fields");
   endtask

   task automatic t_hold_and_latency;
      run_one(1'b0, 64'h3F80_0000, 10'h080, "R9 setup +norm");
      @(negedge clk);
      operand = 64'h7F80_0001;
      fmt_dbl = 1'b1;
      @(negedge clk);
      check(out_valid === 1'b0, "R9 valid drops after idle",
            {63'b0, out_valid}, 64'h0);
      check(class_mask === 64'h80, "R10 mask held while idle",
            class_mask, 64'h80);
   endtask

   task automatic t_narrow;
      @(negedge clk);
      in_valid_n = 1'b1;
      fmt_dbl_n  = 1'b1;
      operand_n  = 32'h7F80_0000;
      @(negedge clk);
      in_valid_n = 1'b0;
      check(out_valid_n === 1'b1 && class_mask_n === 16'h0040,
            "R12 single-only ignores fmt_dbl, R8 pad",
            {48'b0, class_mask_n}, 64'h40);
      @(negedge clk);
      in_valid_n = 1'b1;
      operand_n  = 32'h807F_FFFF;
      @(negedge clk);
      in_valid_n = 1'b0;
      check(out_valid_n === 1'b1 && class_mask_n === 16'h0010,
            "R12 single-only -sub",
            {48'b0, class_mask_n}, 64'h10);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog R9: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_single_classes();
      t_single_ignores_upper();
      t_double_classes();
      t_hold_and_latency();
      t_narrow();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule